// File: doc/BRIEF.md
# Bus Interrupt Requester with Status Vector

This block turns two interrupt causes from a data acquisition path into a request on one of seven bus interrupt lines. One cause is the sample FIFO reaching full, which the FIFO reports as a level. The other is the end of a conversion scan, which arrives as a single-cycle pulse. Each cause is held in a sticky pending flag. The request goes out on the line that a 3-bit level register selects. A level of zero masks every request.

Software writes four registers: an 8-bit status/ID vector, the 3-bit level, a one-bit enable for the FIFO-full cause, and a clear strobe. The clear strobe takes any data value and drops both flags together. The FIFO-full flag cannot be dropped while the FIFO is still full. Software can always read the two pending flags. During an interrupt-acknowledge cycle, the requester answers with its vector, but only when the acknowledged level is its own programmed level.

Top module: `irq_requester`

## Requirements
- R1: After reset, the vector, level and FIFO-full enable registers are 0, both pending flags are 0, no request line is active, and the acknowledge outputs are 0.
- R2: A cycle with `scanDone` high sets the scan flag, which reads as `pending[0]`, at the next clock edge. If a clear write arrives in the same cycle, the flag still ends up set.
- R3: A cycle with `fifoFull` high sets the FIFO-full flag, which reads as `pending[1]`, at the next clock edge, whatever the enable register holds.
- R4: `irqLines[k]` stands for request line k+1. Exactly that line is high when the level is k+1 and an enabled flag is set. An enabled flag is the scan flag, or the FIFO-full flag while the enable is 1. Otherwise all lines are low. A level of 0 keeps all lines low.
- R5: While the enable is 0, a set FIFO-full flag raises no request line. Setting the enable to 1 raises the line while the flag is still set.
- R6: A write with `regSel`=2 clears both flags at the next edge, whatever its data. In a cycle where `fifoFull` is high, the FIFO-full flag stays set.
- R7: When `ackValid` is high, `ackLevel` equals the programmed level, and the level is nonzero, `ackHit` is 1 and `ackVector` carries the vector register. In every other case both outputs are 0.
- R8: Writes take effect at the next edge when `regWrEn` is high. `regSel`=0 loads the vector from bits 7:0, `regSel`=1 loads the level from bits 2:0, and `regSel`=3 loads the enable from bit 0. A write with `regWrEn` low changes nothing.
- R9: At most one request line is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 vector, 1 level, 2 clear, 3 FIFO-full enable |
| regWrData | input | 8 | Write data |
| fifoFull | input | 1 | FIFO full level |
| scanDone | input | 1 | Scan complete pulse |
| irqLines | output | 7 | Request lines 1 to 7, active high |
| pending | output | 2 | Pending flags: bit 1 FIFO full, bit 0 scan done |
| ackValid | input | 1 | Interrupt-acknowledge cycle in progress |
| ackLevel | input | 3 | Level being acknowledged |
| ackHit | output | 1 | This requester answers the acknowledge |
| ackVector | output | 8 | Status/ID vector returned on a hit |

## Verification
Register writes and cause events change the flags and registers at the first clock edge after the cycle in which they are presented. The pending flags and the request lines follow those registers with no further delay, so they are due one cycle after the stimulus. The acknowledge outputs are combinational from the acknowledge inputs and the stored registers, so they are due in the same cycle as the acknowledge. The bench updates its reference model at each rising edge, then compares every output 2 ns later, before it drives the next inputs.

// File: rtl/irq_req_pkg.sv
package irq_req_pkg;
  localparam int SEL_W = 2;
  localparam logic [SEL_W-1:0] SEL_VECTOR = 2'd0;
  localparam logic [SEL_W-1:0] SEL_LEVEL  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CLEAR  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_FULLEN = 2'd3;

  typedef struct packed {
    logic wrVector;
    logic wrLevel;
    logic wrClear;
    logic wrFullEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_req_datapath.sv
module irq_req_datapath
  import irq_req_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int LEVEL_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [VEC_W-1:0]   regWrData,
  input  logic               fifoFull,
  input  logic               scanDone,
  output logic [VEC_W-1:0]   vectorReg,
  output logic [LEVEL_W-1:0] levelReg,
  output logic               fullEnReg,
  output logic               scanFlag,
  output logic               fullFlag
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vectorReg <= '0;
      levelReg  <= '0;
      fullEnReg <= 1'b0;
      scanFlag  <= 1'b0;
      fullFlag  <= 1'b0;
    end else begin
      if (strobes.wrVector) vectorReg <= regWrData;
      if (strobes.wrLevel)  levelReg  <= regWrData[LEVEL_W-1:0];
      if (strobes.wrFullEn) fullEnReg <= regWrData[0];
      // A new event outranks a clear arriving in the same cycle
      scanFlag <= scanDone | (scanFlag & ~strobes.wrClear);
      // Full level re-sets the flag, so a clear cannot drop it while full
      fullFlag <= fifoFull | (fullFlag & ~strobes.wrClear);
    end
  end
endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_req_pkg::*;
#(
  parameter int LINES   = 7,
  parameter int VEC_W   = 8,
  parameter int LEVEL_W = 3
) (
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  output ctrlStrobes_t       strobes,
  input  logic [VEC_W-1:0]   vectorReg,
  input  logic [LEVEL_W-1:0] levelReg,
  input  logic               fullEnReg,
  input  logic               scanFlag,
  input  logic               fullFlag,
  output logic [LINES-1:0]   irqLines,
  input  logic               ackValid,
  input  logic [LEVEL_W-1:0] ackLevel,
  output logic               ackHit,
  output logic [VEC_W-1:0]   ackVector
);
  logic reqActive;

  always_comb begin
    strobes.wrVector = regWrEn && (regSel == SEL_VECTOR);
    strobes.wrLevel  = regWrEn && (regSel == SEL_LEVEL);
    strobes.wrClear  = regWrEn && (regSel == SEL_CLEAR);
    strobes.wrFullEn = regWrEn && (regSel == SEL_FULLEN);
  end

  assign reqActive = scanFlag | (fullFlag & fullEnReg);

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign irqLines[i] = reqActive && (levelReg == LEVEL_W'(i + 1));
  end

  assign ackHit    = ackValid && (levelReg != '0) && (ackLevel == levelReg);
  assign ackVector = ackHit ? vectorReg : '0;
endmodule

// File: rtl/irq_requester.sv
module irq_requester
  import irq_req_pkg::*;
#(
  parameter int LINES = 7,
  parameter int VEC_W = 8,
  localparam int LEVEL_W = $clog2(LINES + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [SEL_W-1:0]   regSel,
  input  logic [VEC_W-1:0]   regWrData,
  input  logic               fifoFull,
  input  logic               scanDone,
  output logic [LINES-1:0]   irqLines,
  output logic [1:0]         pending,
  input  logic               ackValid,
  input  logic [LEVEL_W-1:0] ackLevel,
  output logic               ackHit,
  output logic [VEC_W-1:0]   ackVector
);
  ctrlStrobes_t       strobes;
  logic [VEC_W-1:0]   vectorReg;
  logic [LEVEL_W-1:0] levelReg;
  logic               fullEnReg, scanFlag, fullFlag;

  irq_req_ctrl #(.LINES(LINES), .VEC_W(VEC_W), .LEVEL_W(LEVEL_W)) u_ctrl (
    .regWrEn(regWrEn), .regSel(regSel), .strobes(strobes),
    .vectorReg(vectorReg), .levelReg(levelReg), .fullEnReg(fullEnReg),
    .scanFlag(scanFlag), .fullFlag(fullFlag), .irqLines(irqLines),
    .ackValid(ackValid), .ackLevel(ackLevel), .ackHit(ackHit), .ackVector(ackVector)
  );

  irq_req_datapath #(.VEC_W(VEC_W), .LEVEL_W(LEVEL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .regWrData(regWrData),
    .fifoFull(fifoFull), .scanDone(scanDone), .vectorReg(vectorReg),
    .levelReg(levelReg), .fullEnReg(fullEnReg), .scanFlag(scanFlag), .fullFlag(fullFlag)
  );

  assign pending = {fullFlag, scanFlag};
endmodule

// File: rtl/irq_requester_checker.sv
module irq_requester_checker #(
  parameter int LINES = 7,
  parameter int VEC_W = 8,
  parameter int LEVEL_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [1:0]         regSel,
  input logic               fifoFull,
  input logic               scanDone,
  input logic [LINES-1:0]   irqLines,
  input logic [1:0]         pending,
  input logic               ackValid,
  input logic               ackHit,
  input logic [VEC_W-1:0]   ackVector
);
  a_r9_one_line: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLines));

  a_r2_scan_sets: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> pending[0]);

  a_r3_full_sets: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |=> pending[1]);

  a_r6_clear_both: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd2 && !fifoFull && !scanDone) |=> (pending == 2'b00));

  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (pending == 2'b00) |-> (irqLines == '0));

  a_r7_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    !ackValid |-> (!ackHit && ackVector == '0));
endmodule

bind irq_requester irq_requester_checker #(.LINES(LINES), .VEC_W(VEC_W), .LEVEL_W(LEVEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .fifoFull(fifoFull),
  .scanDone(scanDone), .irqLines(irqLines), .pending(pending), .ackValid(ackValid),
  .ackHit(ackHit), .ackVector(ackVector)
);

// File: tb/irq_requester_bench.sv
module irq_requester_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] regWrData = '0;
  logic       fifoFull = 1'b0, scanDone = 1'b0, ackValid = 1'b0;
  logic [2:0] ackLevel = '0;
  logic [6:0] irqLines;
  logic [1:0] pending;
  logic       ackHit;
  logic [7:0] ackVector;

  int checks = 0, failures = 0;
  int mVec = 0, mLvl = 0, mEn = 0, mScan = 0, mFull = 0;
  bit done = 0;

  irq_requester u_irq_requester (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .fifoFull(fifoFull), .scanDone(scanDone), .irqLines(irqLines), .pending(pending),
    .ackValid(ackValid), .ackLevel(ackLevel), .ackHit(ackHit), .ackVector(ackVector)
  );

  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference model step at the rising edge, then compare 2 ns later
  task automatic cycle(string tag);
    int expLines, expHit, expVec;
    bit clr;
    @(posedge clk);
    if (!rstN) begin
      mVec = 0; mLvl = 0; mEn = 0; mScan = 0; mFull = 0;
    end else begin
      clr = regWrEn && regSel == 2;
      mScan = scanDone ? 1 : (clr ? 0 : mScan);
      mFull = fifoFull ? 1 : (clr ? 0 : mFull);
      if (regWrEn && regSel == 0) mVec = regWrData;
      if (regWrEn && regSel == 1) mLvl = regWrData & 7;
      if (regWrEn && regSel == 3) mEn = regWrData & 1;
    end
    #2;
    expLines = (mLvl != 0 && (mScan != 0 || (mFull != 0 && mEn != 0))) ? (1 << (mLvl - 1)) : 0;
    expHit = (ackValid && mLvl != 0 && ackLevel == mLvl) ? 1 : 0;
    expVec = expHit ? mVec : 0;
    check({tag, " R4 irqLines"}, irqLines, expLines);
    check({tag, " R2 pending"}, pending, (mFull << 1) | mScan);
    check({tag, " R7 ackHit"}, ackHit, expHit);
    check({tag, " R7 ackVector"}, ackVector, expVec);
  endtask

  task automatic drive(bit we, int sel, int data, bit ff, bit sd, bit av, int al, string tag);
    regWrEn = we; regSel = 2'(sel); regWrData = 8'(data);
    fifoFull = ff; scanDone = sd; ackValid = av; ackLevel = 3'(al);
    cycle(tag);
  endtask

  task automatic idle(string tag);
    drive(0, 0, 0, fifoFull, 0, 0, 0, tag);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) cycle("R1 reset");
    rstN = 1'b1;
    idle("R1 after reset");
    check("R1 lines zero", irqLines, 0);
    check("R1 pending zero", pending, 0);
    // R8: registers loaded only when the write strobe is high
    drive(0, 1, 3, 0, 0, 0, 0, "R8 write disabled");
    drive(0, 0, 8'h5A, 0, 0, 1, 3, "R8 ack without level");
    check("R8 ignored write", ackHit, 0);
    drive(1, 0, 8'hA7, 0, 0, 0, 0, "R8 vector");
    // R4: level 0 masks a pending scan
    drive(0, 0, 0, 0, 1, 0, 0, "R2 scan pulse");
    check("R4 masked level", irqLines, 0);
    drive(1, 1, 8'hF3, 0, 0, 0, 0, "R8 level 3");
    check("R4 line 3", irqLines, 7'b0000100);
    drive(0, 0, 0, 0, 0, 1, 3, "R7 ack match");
    check("R7 hit", ackHit, 1);
    check("R7 vector", ackVector, 8'hA7);
    drive(0, 0, 0, 0, 0, 1, 5, "R7 ack other level");
    check("R7 miss", ackHit, 0);
    drive(1, 2, 8'h00, 0, 0, 0, 0, "R6 clear");
    check("R6 cleared", pending, 0);
    // R3/R5: full flag set regardless of enable, gated from request
    drive(0, 0, 0, 1, 0, 0, 0, "R3 full high");
    drive(0, 0, 0, 0, 0, 0, 0, "R3 full low");
    check("R3 flag set", pending, 2'b10);
    check("R5 gated", irqLines, 0);
    drive(1, 3, 8'hFF, 0, 0, 0, 0, "R5 enable");
    check("R5 enabled line", irqLines, 7'b0000100);
    // R6: clear while full keeps the full flag, scan with clear stays set
    drive(0, 0, 0, 1, 0, 0, 0, "R6 full again");
    drive(1, 2, 8'h3C, 1, 1, 0, 0, "R6 clear while full");
    check("R6 full kept", pending, 2'b11);
    drive(1, 2, 8'h99, 0, 0, 0, 0, "R6 clear after drain");
    check("R6 both cleared", pending, 0);
    // walk every level for R9 and R4
    for (int l = 0; l < 8; l++) begin
      drive(1, 1, l, 0, 1, 0, 0, "R9 level walk");
      idle("R9 walk settle");
      check("R9 one line", $countones(irqLines), (l == 0) ? 0 : 1);
      drive(0, 0, 0, 0, 0, 1, l, "R7 walk ack");
    end
    drive(1, 2, 0, 0, 0, 0, 0, "R6 final clear");
    for (int i = 0; i < 200; i++)
      drive(i % 7 == 0, i % 4, i * 37, (i % 11) < 3, i % 5 == 0, i % 3 == 0, i % 8, "mixed");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule